// File: doc/BRIEF.md
# Pipelined Wide Word Selector Tree

This block picks one W-bit word out of N words presented side by side on a flat input bus and hands it on together with a valid flag. The selection runs as a binary tree. The word set is split into an upper half and a lower half, each half is reduced on its own, and the two partial results are merged. The bottom level gates every word with its bit from a decoded one-hot select and merges pairs. Each level above it only ORs two children, because every branch that was not chosen already carries zero.

Registers can be placed in two ways. In per-level mode, one register bank follows every level of the tree. In trailing mode, the tree is purely combinational and a chain of a parameterised number of registers follows it, which a synthesis tool can move back into the tree by retiming. With a chain of length zero the block is a plain combinational selector. The valid flag passes through the same registers as the data. A new select index and word set can be presented on every clock.

Top module: `pmux_tree`

## Requirements
- R1: When the select index k is below N, the output word equals input word k, which occupies bits [k*W+W-1 : k*W] of the input bus.
- R2: A select index of N or more (input words padded up to the next power of two included) produces an all-zero output word.
- R3: In per-level mode the latency from input to output is ceil(log2 N) rising clock edges.
- R4: In trailing mode the latency equals the trailing stage count parameter.
- R5: In trailing mode with a stage count of zero, the output word and valid follow the inputs with no clock edge in between.
- R6: While the active-low reset is low, every registered output reads zero immediately, without waiting for a clock edge.
- R7: Consecutive cycles may carry different selects and data, and each result comes out in its own consecutive cycle, one per clock.
- R8: The output valid is the input valid delayed by exactly the same number of edges as the data.
- R9: The boundary indices 0 and N-1 select the first and last real words, even when N is not a power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock for all pipeline registers |
| rst_ni | input | 1 | Asynchronous active-low reset; clears all registers |
| in_valid_i | input | 1 | Marks the current select and word set as meaningful |
| in_sel_i | input | SEL_W | Index of the word to pick |
| in_data_i | input | N*W | N words; word k sits at bits k*W upward |
| out_valid_o | output | 1 | Valid flag aligned to out_data_o |
| out_data_o | output | W | Selected word, or zero for an out-of-range index |

## Verification
The bench runs three instances side by side: one in per-level mode, one with a three-stage trailing chain and one with no stages. This exposes a latency off by one edge, or a valid that runs out of step with its word, as a mismatch at a fixed cycle. Indices 0 and N-1 with N=12 check that the zero padding does not shift the word order. A tree that got the padding or the halving wrong would return a neighbouring word. Indices 12 to 15 must give zero, so a decoder that wraps around or ignores the top select bits would leak a real or padded word. A reset applied in the middle of a run is sampled before any clock edge, which catches registers that clear only synchronously. A walk through all indices on consecutive cycles catches any stage that holds or skips a result.

// File: rtl/pmux_tree_pkg.sv
package pmux_tree_pkg;

   typedef enum logic [0:0] {
      PIPE_PER_LEVEL = 1'b0,
      PIPE_TRAILING  = 1'b1
   } pipe_mode_e;

   // number of pairwise merge levels for n inputs
   function automatic int unsigned tree_levels(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   function automatic int unsigned pipe_latency(input pipe_mode_e mode,
                                                input int unsigned levels,
                                                input int unsigned trail);
      return (mode == PIPE_PER_LEVEL) ? levels : trail;
   endfunction

endpackage

// File: rtl/pmux_sel_decode.sv
module pmux_sel_decode #(
   parameter int unsigned N     = 12,
   parameter int unsigned SEL_W = 4,
   parameter int unsigned P     = 16
) (
   input  logic [SEL_W-1:0] sel_i,
   output logic [P-1:0]     onehot_o
);

   // indices at or above N leave every bit clear
   always_comb begin
      onehot_o = '0;
      for (int i = 0; i < int'(N); i++) begin
         if (sel_i == SEL_W'(i)) onehot_o[i] = 1'b1;
      end
   end

endmodule

// File: rtl/pmux_leaf_level.sv
module pmux_leaf_level #(
   parameter int unsigned W = 16,
   parameter int unsigned P = 16
) (
   input  logic [P*W-1:0]     data_i,
   input  logic [P-1:0]       onehot_i,
   output logic [(P/2)*W-1:0] data_o
);

   // gate each word with its select bit, then merge neighbours
   always_comb begin
      for (int j = 0; j < int'(P/2); j++) begin
         data_o[j*W +: W] = (data_i[(2*j)*W +: W]   & {W{onehot_i[2*j]}})
                          | (data_i[(2*j+1)*W +: W] & {W{onehot_i[2*j+1]}});
      end
   end

endmodule

// File: rtl/pmux_or_level.sv
module pmux_or_level #(
   parameter int unsigned W     = 16,
   parameter int unsigned NODES = 4
) (
   input  logic [2*NODES*W-1:0] data_i,
   output logic [NODES*W-1:0]   data_o
);

   always_comb begin
      for (int j = 0; j < int'(NODES); j++) begin
         data_o[j*W +: W] = data_i[(2*j)*W +: W] | data_i[(2*j+1)*W +: W];
      end
   end

endmodule

// File: rtl/pmux_stage.sv
module pmux_stage #(
   parameter int unsigned WIDTH = 8,
   parameter bit          REG   = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (REG) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) q_o <= '0;
         else         q_o <= d_i;
      end
   end else begin : g_wire
      logic unused_clk_rst;
      assign unused_clk_rst = clk_i ^ rst_ni;
      assign q_o = d_i;
   end

endmodule

// File: rtl/pmux_tree.sv
module pmux_tree
   import pmux_tree_pkg::*;
#(
   parameter int unsigned N            = 12,
   parameter int unsigned W            = 16,
   parameter int unsigned SEL_W        = 4,
   parameter pipe_mode_e  MODE         = PIPE_PER_LEVEL,
   parameter int unsigned TRAIL_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             in_valid_i,
   input  logic [SEL_W-1:0] in_sel_i,
   input  logic [N*W-1:0]   in_data_i,
   output logic             out_valid_o,
   output logic [W-1:0]     out_data_o
);

   localparam int unsigned LEVELS    = tree_levels(N);
   localparam int unsigned P         = 1 << LEVELS;
   localparam bit          PER_LEVEL = (MODE == PIPE_PER_LEVEL);
   localparam int unsigned LATENCY   = pipe_latency(MODE, LEVELS, TRAIL_STAGES);

   if (N < 2) begin : g_bad_n
      $error("pmux_tree: N must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("pmux_tree: W must be at least 1");
   end
   if (SEL_W < $clog2(N) || SEL_W > 16) begin : g_bad_sel
      $error("pmux_tree: SEL_W must cover N and stay at most 16");
   end

   logic [P*W-1:0] pad_data;
   logic [P-1:0]   onehot;

   // unused tail words read as zero
   assign pad_data = (P*W)'(in_data_i);

   pmux_sel_decode #(.N(N), .SEL_W(SEL_W), .P(P)) u_dec (
      .sel_i    (in_sel_i),
      .onehot_o (onehot)
   );

   for (genvar k = 1; k <= int'(LEVELS); k++) begin : g_lvl
      localparam int unsigned NODES = P >> k;
      logic [NODES*W-1:0] comb_w;
      logic [NODES*W-1:0] reg_w;
      logic               reg_v;
      logic               prev_v;

      if (k == 1) begin : g_leaf
         assign prev_v = in_valid_i;
         pmux_leaf_level #(.W(W), .P(P)) u_leaf (
            .data_i   (pad_data),
            .onehot_i (onehot),
            .data_o   (comb_w)
         );
      end else begin : g_upper
         assign prev_v = g_lvl[k-1].reg_v;
         pmux_or_level #(.W(W), .NODES(NODES)) u_or (
            .data_i (g_lvl[k-1].reg_w),
            .data_o (comb_w)
         );
      end

      pmux_stage #(.WIDTH(NODES*W+1), .REG(PER_LEVEL)) u_stg (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .d_i    ({prev_v, comb_w}),
         .q_o    ({reg_v, reg_w})
      );
   end

   logic [W-1:0] tree_d;
   logic         tree_v;
   assign tree_d = g_lvl[LEVELS].reg_w;
   assign tree_v = g_lvl[LEVELS].reg_v;

   if (!PER_LEVEL && TRAIL_STAGES > 0) begin : g_trail
      logic [W:0] chain [TRAIL_STAGES+1];
      assign chain[0] = {tree_v, tree_d};
      for (genvar t = 0; t < int'(TRAIL_STAGES); t++) begin : g_tr
         pmux_stage #(.WIDTH(W+1), .REG(1'b1)) u_tr (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .d_i    (chain[t]),
            .q_o    (chain[t+1])
         );
      end
      assign {out_valid_o, out_data_o} = chain[TRAIL_STAGES];
   end else begin : g_direct
      assign {out_valid_o, out_data_o} = {tree_v, tree_d};
   end

endmodule

// File: rtl/pmux_tree_chk.sv
module pmux_tree_chk #(
   parameter int unsigned N     = 12,
   parameter int unsigned W     = 16,
   parameter int unsigned SEL_W = 4,
   parameter int unsigned LAT   = 4
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             in_valid_i,
   input logic [SEL_W-1:0] in_sel_i,
   input logic [N*W-1:0]   in_data_i,
   input logic             out_valid_o,
   input logic [W-1:0]     out_data_o
);

   logic [W-1:0] want_now;
   logic         oor_now;

   always_comb begin
      want_now = '0;
      for (int i = 0; i < int'(N); i++) begin
         if (int'(in_sel_i) == i) want_now = in_data_i[i*W +: W];
      end
   end
   assign oor_now = (int'(in_sel_i) >= int'(N));

   if (LAT > 0) begin : g_seq
      logic [W-1:0] dh [LAT];
      logic         vh [LAT];
      logic         oh [LAT];

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            for (int i = 0; i < int'(LAT); i++) begin
               dh[i] <= '0;
               vh[i] <= 1'b0;
               oh[i] <= 1'b0;
            end
         end else begin
            dh[0] <= want_now;
            vh[0] <= in_valid_i;
            oh[0] <= oor_now;
            for (int i = 1; i < int'(LAT); i++) begin
               dh[i] <= dh[i-1];
               vh[i] <= vh[i-1];
               oh[i] <= oh[i-1];
            end
         end
      end

      // R1 / R3 / R4: word appears LAT edges after it was presented
      a_r1_word_after_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
         out_data_o == dh[LAT-1]);
      // R8: valid flag delayed identically
      a_r8_valid_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
         out_valid_o == vh[LAT-1]);
      // R2: out-of-range index yields zero
      a_r2_out_of_range_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
         oh[LAT-1] |-> (out_data_o == '0));
      // R6: registered outputs held at zero during reset
      a_r6_reset_clears: assert property (@(posedge clk_i)
         !rst_ni |-> (out_data_o == '0 && !out_valid_o));
   end else begin : g_comb
      // R5: zero stages follow the inputs directly
      a_r5_comb_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
         out_data_o == want_now);
      a_r5_comb_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
         out_valid_o == in_valid_i);
      // R2: out-of-range index yields zero
      a_r2_out_of_range_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
         oor_now |-> (out_data_o == '0));
      // R1: in-range index with a nonzero word gives a nonzero output
      a_r1_nonzero_pick: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!oor_now && want_now != '0) |-> (out_data_o != '0));
   end

endmodule

bind pmux_tree pmux_tree_chk #(
   .N     (N),
   .W     (W),
   .SEL_W (SEL_W),
   .LAT   (LATENCY)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .in_valid_i  (in_valid_i),
   .in_sel_i    (in_sel_i),
   .in_data_i   (in_data_i),
   .out_valid_o (out_valid_o),
   .out_data_o  (out_data_o)
);

// File: tb/sim_pmux_tree.sv
module sim_pmux_tree;
   import pmux_tree_pkg::*;

   localparam int unsigned N     = 12;
   localparam int unsigned W     = 16;
   localparam int unsigned SEL_W = 4;
   localparam int unsigned LAT0  = 4;   // ceil(log2 12)
   localparam int unsigned LAT1  = 3;
   localparam int unsigned HD    = 5;

   logic             clk = 1'b0;
   logic             rst_ni = 1'b1;
   logic             in_valid = 1'b0;
   logic [SEL_W-1:0] in_sel = '0;
   logic [N*W-1:0]   in_data = '0;

   logic         v0, v1, v2;
   logic [W-1:0] d0, d1, d2;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [W-1:0] hd [HD];
   logic         hv [HD];
   string        ht [HD];

   always #4 clk = ~clk;

   pmux_tree #(.N(N), .W(W), .SEL_W(SEL_W), .MODE(PIPE_PER_LEVEL), .TRAIL_STAGES(0)) u0 (
      .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_sel_i(in_sel),
      .in_data_i(in_data), .out_valid_o(v0), .out_data_o(d0));
   pmux_tree #(.N(N), .W(W), .SEL_W(SEL_W), .MODE(PIPE_TRAILING), .TRAIL_STAGES(LAT1)) u1 (
      .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_sel_i(in_sel),
      .in_data_i(in_data), .out_valid_o(v1), .out_data_o(d1));
   pmux_tree #(.N(N), .W(W), .SEL_W(SEL_W), .MODE(PIPE_TRAILING), .TRAIL_STAGES(0)) u2 (
      .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_sel_i(in_sel),
      .in_data_i(in_data), .out_valid_o(v2), .out_data_o(d2));

   function automatic logic [W-1:0] pick(input logic [N*W-1:0] d, input logic [SEL_W-1:0] s);
      if (int'(s) < int'(N)) return d[int'(s)*W +: W];
      return '0;
   endfunction

   function automatic logic [N*W-1:0] rand_words();
      logic [N*W-1:0] r;
      for (int i = 0; i < int'(N); i++) r[i*W +: W] = W'($urandom);
      return r;
   endfunction

   task automatic chk(input string req, input string who, input logic [W:0] act, input logic [W:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, who, act, exp);
      end
   endtask

   task automatic clear_hist();
      for (int k = 0; k < int'(HD); k++) begin
         hd[k] = '0; hv[k] = 1'b0; ht[k] = "R6";
      end
   endtask

   task automatic step(input logic v, input logic [SEL_W-1:0] s, input logic [N*W-1:0] d, input string tag);
      @(negedge clk);
      for (int k = HD-1; k > 0; k--) begin
         hd[k] = hd[k-1]; hv[k] = hv[k-1]; ht[k] = ht[k-1];
      end
      hd[0] = pick(d, s); hv[0] = v; ht[0] = tag;
      in_valid = v; in_sel = s; in_data = d;
      #1;
      chk({ht[LAT0], "/R3"}, "u0 word",  {1'b0, d0}, {1'b0, hd[LAT0]});
      chk({ht[LAT0], "/R8"}, "u0 valid", {{W{1'b0}}, v0}, {{W{1'b0}}, hv[LAT0]});
      chk({ht[LAT1], "/R4"}, "u1 word",  {1'b0, d1}, {1'b0, hd[LAT1]});
      chk({ht[LAT1], "/R8"}, "u1 valid", {{W{1'b0}}, v1}, {{W{1'b0}}, hv[LAT1]});
      chk({ht[0], "/R5"}, "u2 word",  {1'b0, d2}, {1'b0, hd[0]});
      chk({ht[0], "/R5"}, "u2 valid", {{W{1'b0}}, v2}, {{W{1'b0}}, hv[0]});
   endtask

   task automatic flush(input int n);
      for (int i = 0; i < n; i++) step(1'b0, '0, '0, "R1");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7741));
      clear_hist();
      #1 rst_ni = 1'b0;
      #1;
      // R6: reset state before any clock edge
      chk("R6", "u0 reset", {v0, d0}, '0);
      chk("R6", "u1 reset", {v1, d1}, '0);
      repeat (3) @(posedge clk);
      @(negedge clk) rst_ni = 1'b1;

      // R9: boundary indices
      step(1'b1, SEL_W'(0),   rand_words(), "R9");
      step(1'b1, SEL_W'(N-1), rand_words(), "R9");
      // R2: out-of-range indices
      step(1'b1, SEL_W'(N),   rand_words(), "R2");
      step(1'b1, SEL_W'(15),  rand_words(), "R2");
      step(1'b0, SEL_W'(5),   rand_words(), "R8");
      flush(HD);

      // R7: every index on consecutive cycles
      for (int s = 0; s < 16; s++) step(1'b1, SEL_W'(s), rand_words(), "R7");
      // R8: alternating valid
      for (int i = 0; i < 8; i++) step(i[0], SEL_W'(i + 2), rand_words(), "R8");
      flush(HD);

      // R1 / R2: random stimulus
      for (int i = 0; i < 1500; i++) begin
         logic [SEL_W-1:0] s;
         s = SEL_W'($urandom % 16);
         step(1'(($urandom % 4) != 0), s, rand_words(), (int'(s) < int'(N)) ? "R1" : "R2");
      end

      // R6: asynchronous reset in the middle of a run
      step(1'b1, SEL_W'(3), rand_words(), "R1");
      step(1'b1, SEL_W'(7), rand_words(), "R1");
      @(negedge clk);
      in_valid = 1'b0; in_sel = '0; in_data = '0;
      rst_ni = 1'b0;
      #1;
      chk("R6", "u0 mid reset", {v0, d0}, '0);
      chk("R6", "u1 mid reset", {v1, d1}, '0);
      clear_hist();
      repeat (2) @(posedge clk);
      @(negedge clk) rst_ni = 1'b1;
      step(1'b1, SEL_W'(11), rand_words(), "R9");
      flush(HD);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule